// File: doc/BRIEF.md
# Assembly Site Type-Check Controller

This controller runs a square grid of binding sites on an active assembly template. When a part settles onto a site, the site becomes pending. A single shared query channel then asks that part for its identification tag. The reply carries the part's type and a parity bit. The controller compares the type with a table of outstanding demand kept for the site's placement region. A part that is still wanted is kept, and the demand for its type in that region drops by one. Any other part is pushed off by a per-site release output. That output stays high for a programmable number of cycles, and then the site goes back to attracting parts.

The grid is divided into square placement regions, each SLACK sites on a side. Demand is counted per region and type, so a part of the right type may land on any site inside its region. With SLACK set to 1, every site is its own region and placement is strict. A site that was filled can lose its part at any time. The controller then gives that part's demand back to the region. A done output is high exactly when every region has zero outstanding demand. Demand counts are written through a simple load port before assembly begins.

Top module: `site_assembly_ctrl`

## Requirements
- R1: After reset all demand counts are zero, so done is 1, and no release output or query request is active.
- R2: A site that sees a part becomes pending. One query is in flight at a time: q_req pulses for one cycle with q_site naming the site, and at most one site is being queried.
- R3: When several sites are pending, they are served in round-robin order, starting with the first pending site after the one served last (site index = row*GRID + column).
- R4: A reply with good parity, for a site whose part is still present, whose type has a nonzero count in the site's region, is accepted. That count drops by one and no release follows.
- R5: The region of a site is (row/SLACK)*(GRID/SLACK) + column/SLACK, and a part is judged only against demand in its own region.
- R6: A part whose type has a zero count in its region gets its site's release output raised.
- R7: The tag type is resp_tag[TYPE_W-1:0], and the whole tag must have even parity (XOR of all bits equal to 0). A tag that fails parity is rejected like a wrong type.
- R8: If no reply arrives, the query ends tmo_cycles+1 cycles after the q_req pulse, and the part is rejected.
- R9: A release output stays high for exactly rel_cycles cycles (at least 1). The site then returns to idle and ignores its presence input while releasing.
- R10: When a kept part leaves its site, the count for its type in its region goes up by one again.
- R11: done is 1 exactly when every demand count is zero.
- R12: A write with cfg_we sets the count for (cfg_region, cfg_type) to cfg_count on the next cycle. It takes priority over any update in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Demand table write strobe |
| cfg_region | input | REG_W | Region written |
| cfg_type | input | TYPE_W | Part type written |
| cfg_count | input | CNT_W | New outstanding count |
| tmo_cycles | input | TMO_W | Reply timeout in cycles |
| rel_cycles | input | REL_W | Release pulse length in cycles |
| site_present | input | GRID*GRID | Part-detected flag per site |
| q_req | output | 1 | One-cycle tag query request |
| q_site | output | SITE_W | Site being queried |
| resp_valid | input | 1 | Tag reply strobe |
| resp_tag | input | TAG_W | Tag reply word |
| release_o | output | GRID*GRID | Per-site repel command |
| done | output | 1 | All demand satisfied |

## Verification
The type check is tried with several replies. A reply whose type matches demand in region 0 tests acceptance. A match placed on a different site of the same region shows that slack placement is honoured. A type with no demand, a reply with broken parity, and a missing reply each test a different route to rejection, and the timeout case also checks the exact length of the wait. Removing a kept part, then filling the restored demand from another site of its region, tests the count return. Two simultaneous arrivals, once in plain order and once across the index wrap, show the round-robin choice.

// File: rtl/site_assembly_ctrl.sv
module site_assembly_ctrl #(
  parameter int GRID   = 4,
  parameter int SLACK  = 2,
  parameter int TYPE_W = 2,
  parameter int TAG_W  = 8,
  parameter int CNT_W  = 4,
  parameter int TMO_W  = 8,
  parameter int REL_W  = 6,
  localparam int NS     = GRID * GRID,
  localparam int SITE_W = $clog2(NS),
  localparam int RSIDE  = GRID / SLACK,
  localparam int NREG   = RSIDE * RSIDE,
  localparam int REG_W  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [REG_W-1:0]  cfg_region,
  input  logic [TYPE_W-1:0] cfg_type,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic [TMO_W-1:0]  tmo_cycles,
  input  logic [REL_W-1:0]  rel_cycles,
  input  logic [NS-1:0]     site_present,
  output logic              q_req,
  output logic [SITE_W-1:0] q_site,
  input  logic              resp_valid,
  input  logic [TAG_W-1:0]  resp_tag,
  output logic [NS-1:0]     release_o,
  output logic              done
);
  localparam int ENT_W = REG_W + TYPE_W;
  localparam int NENT  = 1 << ENT_W;

  typedef enum logic [2:0] {S_IDLE, S_PEND, S_QUERY, S_HELD, S_EJECT} site_st_t;

  site_st_t          st    [NS];
  logic [TYPE_W-1:0] styp  [NS];
  logic [REL_W-1:0]  ecnt  [NS];
  logic [CNT_W-1:0]  cnt   [NENT];
  logic [CNT_W-1:0]  cnt_nx[NENT];

  logic              busy;
  logic [SITE_W-1:0] cur, last;
  logic [TMO_W-1:0]  timer;
  logic [SITE_W-1:0] sel;
  logic              sel_ok, grant, fin, accept;
  logic [NS-1:0]     lost, querying;
  logic [ENT_W-1:0]  cur_ent;
  logic [REL_W-1:0]  rel_len;

  function automatic logic [REG_W-1:0] region_of(input int s);
    return REG_W'(((s / GRID) / SLACK) * RSIDE + (s % GRID) / SLACK);
  endfunction

  assign q_site  = cur;
  assign grant   = !busy && sel_ok;
  assign fin     = busy && (resp_valid || timer == tmo_cycles);
  assign cur_ent = {region_of(int'(cur)), resp_tag[TYPE_W-1:0]};
  assign accept  = fin && resp_valid && !(^resp_tag) && site_present[cur] && cnt[cur_ent] != '0;
  assign rel_len = (rel_cycles == '0) ? REL_W'(1) : rel_cycles;

  always_comb begin
    int idx;
    sel    = '0;
    sel_ok = 1'b0;
    for (int i = 1; i <= NS; i++) begin
      idx = (int'(last) + i) % NS;
      if (!sel_ok && st[idx] == S_PEND) begin
        sel_ok = 1'b1;
        sel    = SITE_W'(idx);
      end
    end
  end

  always_comb begin
    for (int s = 0; s < NS; s++) begin
      lost[s]      = (st[s] == S_HELD) && !site_present[s];
      querying[s]  = (st[s] == S_QUERY);
      release_o[s] = (st[s] == S_EJECT);
    end
  end

  always_comb begin
    done = 1'b1;
    for (int e = 0; e < NENT; e++) begin
      cnt_nx[e] = cnt[e];
      for (int s = 0; s < NS; s++)
        if (lost[s] && {region_of(s), styp[s]} == ENT_W'(e)) cnt_nx[e] = cnt_nx[e] + 1'b1;
      if (accept && cur_ent == ENT_W'(e)) cnt_nx[e] = cnt_nx[e] - 1'b1;
      if (cfg_we && {cfg_region, cfg_type} == ENT_W'(e)) cnt_nx[e] = cfg_count;
      if (cnt[e] != '0) done = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      q_req <= 1'b0;
      cur   <= '0;
      last  <= SITE_W'(NS - 1);
      timer <= '0;
      for (int e = 0; e < NENT; e++) cnt[e] <= '0;
      for (int s = 0; s < NS; s++) begin
        st[s]   <= S_IDLE;
        styp[s] <= '0;
        ecnt[s] <= '0;
      end
    end else begin
      for (int e = 0; e < NENT; e++) cnt[e] <= cnt_nx[e];
      if (grant) begin
        busy  <= 1'b1;
        q_req <= 1'b1;
        cur   <= sel;
        last  <= sel;
        timer <= '0;
      end else begin
        q_req <= 1'b0;
        if (fin) busy <= 1'b0;
        else if (busy) timer <= timer + 1'b1;
      end
      for (int s = 0; s < NS; s++) begin
        case (st[s])
          S_IDLE:  if (site_present[s]) st[s] <= S_PEND;
          S_PEND:
            if (!site_present[s]) st[s] <= S_IDLE;
            else if (grant && sel == SITE_W'(s)) st[s] <= S_QUERY;
          S_QUERY:
            if (fin && cur == SITE_W'(s)) begin
              if (accept) begin
                st[s]   <= S_HELD;
                styp[s] <= resp_tag[TYPE_W-1:0];
              end else if (site_present[s]) begin
                st[s]   <= S_EJECT;
                ecnt[s] <= rel_len;
              end else begin
                st[s] <= S_IDLE;
              end
            end
          S_HELD:  if (!site_present[s]) st[s] <= S_IDLE;
          S_EJECT:
            if (ecnt[s] <= REL_W'(1)) st[s] <= S_IDLE;
            else ecnt[s] <= ecnt[s] - 1'b1;
          default: st[s] <= S_IDLE;
        endcase
      end
    end
  end

  assert_single_query_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(querying) <= 1);

  assert_req_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    q_req |=> !q_req);

  for (genvar g = 0; g < NS; g++) begin : g_rel_chk
    assert_release_after_check_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(release_o[g]) |-> $past(fin) && $past(cur) == SITE_W'(g));
  end

  assert_done_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done && !cfg_we && lost == '0 |=> done);

  assert_cfg_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_count != '0 |=> !done);
endmodule

// File: tb/site_assembly_ctrl_bench.sv
module site_assembly_ctrl_bench;
  localparam int TMO = 20;
  localparam int REL = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_region = '0;
  logic [1:0]  cfg_type = '0;
  logic [3:0]  cfg_count = '0;
  logic [7:0]  tmo_cycles = 8'(TMO);
  logic [5:0]  rel_cycles = 6'(REL);
  logic [15:0] site_present = '0;
  logic        q_req;
  logic [3:0]  q_site;
  logic        resp_valid = 1'b0;
  logic [7:0]  resp_tag = '0;
  logic [15:0] release_o;
  logic        done;

  site_assembly_ctrl u_site_assembly_ctrl (
    .clk, .rst_n, .cfg_we, .cfg_region, .cfg_type, .cfg_count, .tmo_cycles,
    .rel_cycles, .site_present, .q_req, .q_site, .resp_valid, .resp_tag,
    .release_o, .done);

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, nq = 0, q_cyc = 0;
  int last_q = 15;
  int hist [64];
  logic mute = 1'b0;
  logic [7:0] tag_of [16];
  logic finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] mk_tag(input int ty, input int id, input bit bad);
    logic [6:0] body;
    body = {5'(id), 2'(ty)};
    return {(^body) ^ bad, body};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (q_req) begin
        last_q = int'(q_site);
        if (nq < 64) hist[nq] = last_q;
        nq++;
        q_cyc = cyc;
        if (!mute) begin
          repeat (2) @(negedge clk);
          resp_tag = tag_of[last_q];
          resp_valid = 1'b1;
          @(negedge clk);
          resp_valid = 1'b0;
        end
      end
    end
  end

  task automatic load(input int r, input int t, input int c);
    @(negedge clk);
    cfg_we = 1'b1; cfg_region = 2'(r); cfg_type = 2'(t); cfg_count = 4'(c);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic place(input int s, input logic [7:0] tag);
    tag_of[s] = tag;
    site_present[s] = 1'b1;
  endtask

  task automatic wait_rel(input int s, output int width);
    int n = 0;
    width = 0;
    while (!release_o[s] && n < 200) begin @(negedge clk); n++; end
    while (release_o[s] && width < 200) begin width++; @(negedge clk); end
  endtask

  task automatic settle_no_release(input int s, output bit seen);
    seen = 1'b0;
    repeat (12) begin @(negedge clk); if (release_o[s]) seen = 1'b1; end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(release_o == '0, "R1 release", int'(release_o), 0);
    check(q_req == 1'b0, "R1 q_req", int'(q_req), 0);
    check(done == 1'b1, "R1 done", int'(done), 1);
  endtask

  task automatic t_load_accept;
    bit seen;
    int n0 = nq;
    load(0, 1, 1);
    @(negedge clk);
    check(done == 1'b0, "R12 done after load", int'(done), 0);
    place(0, mk_tag(1, 3, 0));
    settle_no_release(0, seen);
    check(nq == n0 + 1 && hist[n0] == 0, "R2 query site", hist[n0], 0);
    check(!seen, "R4 no release on accept", int'(seen), 0);
    check(done == 1'b1, "R11 done after fill", int'(done), 1);
  endtask

  task automatic t_slack;
    bit seen;
    load(0, 2, 1);
    place(5, mk_tag(2, 4, 0));
    settle_no_release(5, seen);
    check(!seen && done == 1'b1, "R5 slack site accepted", int'(done), 1);
  endtask

  task automatic t_wrong_type;
    int w, n0;
    place(1, mk_tag(3, 5, 0));
    wait_rel(1, w);
    check(w == REL, "R6 R9 release width", w, REL);
    site_present[1] = 1'b0;
    n0 = nq;
    repeat (10) @(negedge clk);
    check(nq == n0 && release_o[1] == 1'b0, "R9 site idle after release", nq - n0, 0);
  endtask

  task automatic t_parity;
    int w;
    bit seen;
    load(1, 0, 1);
    place(2, mk_tag(0, 6, 1));
    wait_rel(2, w);
    check(w == REL, "R7 bad parity released", w, REL);
    check(done == 1'b0, "R7 demand kept", int'(done), 0);
    site_present[2] = 1'b0;
    place(3, mk_tag(0, 7, 0));
    settle_no_release(3, seen);
    check(!seen && done == 1'b1, "R4 region1 accept", int'(done), 1);
  endtask

  task automatic t_timeout;
    int n = 0, n0;
    bit seen;
    load(1, 1, 1);
    mute = 1'b1;
    n0 = nq;
    place(6, mk_tag(1, 8, 0));
    while (!release_o[6] && n < 200) begin @(negedge clk); n++; end
    check(nq == n0 + 1 && cyc - q_cyc == TMO + 1, "R8 timeout delay", cyc - q_cyc, TMO + 1);
    check(done == 1'b0, "R8 demand kept", int'(done), 0);
    site_present[6] = 1'b0;
    while (release_o[6]) @(negedge clk);
    mute = 1'b0;
    @(negedge clk);
    place(6, mk_tag(1, 8, 0));
    settle_no_release(6, seen);
    check(!seen && done == 1'b1, "R8 retry accepted", int'(done), 1);
  endtask

  task automatic t_loss;
    bit seen;
    site_present[0] = 1'b0;
    repeat (2) @(negedge clk);
    check(done == 1'b0, "R10 count restored", int'(done), 0);
    place(4, mk_tag(1, 9, 0));
    settle_no_release(4, seen);
    check(!seen && done == 1'b1, "R10 refilled in region", int'(done), 1);
  endtask

  task automatic t_round_robin;
    int n0, ea, eb, w;
    load(2, 0, 1);
    load(3, 0, 1);
    n0 = nq;
    ea = ((8 - last_q - 1 + 32) % 16) < ((10 - last_q - 1 + 32) % 16) ? 8 : 10;
    eb = (ea == 8) ? 10 : 8;
    @(negedge clk);
    place(8, mk_tag(0, 10, 0));
    place(10, mk_tag(0, 11, 0));
    repeat (20) @(negedge clk);
    check(nq == n0 + 2 && hist[n0] == ea, "R3 first served", hist[n0], ea);
    check(hist[n0 + 1] == eb, "R3 second served", hist[n0 + 1], eb);
    check(done == 1'b1, "R5 regions 2 and 3 filled", int'(done), 1);
    n0 = nq;
    @(negedge clk);
    place(13, mk_tag(3, 12, 0));
    place(9, mk_tag(3, 13, 0));
    wait_rel(9, w);
    check(nq >= n0 + 2 && hist[n0] == 13 && hist[n0 + 1] == 9, "R3 wrap order", hist[n0], 13);
    site_present[13] = 1'b0;
    site_present[9] = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_load_accept();
    t_slack();
    t_wrong_type();
    t_parity();
    t_timeout();
    t_loss();
    t_round_robin();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule